// File: doc/BRIEF.md
# Run/Pause/Reset State Sequencer for a Serial Peripheral

This block sequences a serial peripheral between three operating states, stopped, active and held, under register writes from a simple write port. Software reads a state word that carries the committed two-bit state code and a settled flag. After every accepted transition the settled flag stays low for a fixed settling window, and software polls it before it issues the next state change. State writes that arrive during the window are dropped.

Leaving the held state for the stopped state is deliberately awkward. The clear code must be written twice in a row. The first write only arms the move, and the second completes it. A soft-reset register returns the block to the stopped state and clears the sticky error flags and their interrupt enables. It then runs the same settling window. Four error flags are set by event pulses from the data path and cleared by writing ones. A level interrupt is raised while any enabled flag is set.

The shift-enable output tells the data path when it may shift. While the block is held, the output buffer can be refilled, and shifting resumes once the block has returned to the active state.

Top module: `xfer_state_ctrl`

## Requirements
- R1: After reset the state word reads 0x0004 (state code 0 = stopped, settled flag in bit 2 set), all error flags read 0, and irq_o and shift_en_o are low.
- R2: A write to address 0 with code 0 (stopped), 1 (active) or 3 (held) in bits [1:0], made while settled, drives the settled flag low for exactly SETTLE_CYC cycles. During that window the state field keeps the old code. The new code appears in the same cycle that the flag returns high.
- R3: A write to address 0 made while the settled flag is low has no effect: it neither changes the committed code nor lengthens the window.
- R4: In the held state, a single write of clear code 2 leaves the state at 3 and the settled flag high. A second consecutive write of 2 starts a settling window that ends in state 0.
- R5: Any other state write between the two clear writes cancels the arming. A write of code 2 outside the held state changes neither the state nor the settled flag.
- R6: Writing 1 to bit 0 of address 1 forces state 0 at once, clears all error flags and all enables, and starts a full settling window. It is accepted even while the settled flag is low. Writing 0 there has no effect.
- R7: Event pulses set sticky flags at fixed bit positions of the error word: err_event_i[0] sets bit 2 (input over-run), [1] sets bit 3 (output under-run), [2] sets bit 4 (input under-run) and [3] sets bit 5 (output over-run).
- R8: A write to address 2 clears exactly those flags whose bit is 1 in the written data. An event in the same cycle wins over the clear.
- R9: The enable register at address 3 uses the same bit positions as the flags. irq_o is high exactly while some flag and its enable are both set.
- R10: shift_en_o is high only while the committed state is active (1) and the settled flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 state, 1 soft reset, 2 error flags, 3 error enables |
| wr_data_i | input | DATA_W | Write data |
| err_event_i | input | NUM_ERR | Error event pulses from the data path |
| state_word_o | output | DATA_W | Bits [1:0] committed state code, bit 2 settled flag |
| err_flags_o | output | DATA_W | Sticky error flags at bits 2 to 5 |
| irq_o | output | 1 | Interrupt, high while an enabled flag is set |
| shift_en_o | output | 1 | Data path may shift |

## Verification
The bench counts the low cycles of the settled flag after each transition. A design that is off by one in its window, or that restarts the window on a write it should drop, shows up in that count. It walks the two-write exit from hold, both as a single write (a design that moves at once ends in state 0) and with an interposed write (a design that forgets to disarm completes the move early). It also fires a soft reset in the middle of a window and raises an error event in the same cycle as its clear. The first catches a design that refuses soft reset while busy. The second catches a design that lets the clear beat the event and loses the error.

// File: rtl/xsc_pkg.sv
package xsc_pkg;

  typedef enum logic [1:0] {
    ST_STOPPED = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_CLEAR   = 2'd2,   // command code only, never committed
    ST_HELD    = 2'd3
  } run_state_e;

  typedef enum logic [1:0] {
    RA_STATE   = 2'd0,
    RA_SOFTRST = 2'd1,
    RA_ERR     = 2'd2,
    RA_ERREN   = 2'd3
  } reg_addr_e;

  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned VALID_POS = 2;

endpackage

// File: rtl/xsc_settle_timer.sv
module xsc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_o = 1'b0;
    if (start_i) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign upd_en = start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/xsc_state_fsm.sv
module xsc_state_fsm
  import xsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_state_i,
  input  logic [1:0] wr_code_i,
  input  logic       soft_rst_i,
  input  logic       busy_i,
  input  logic       done_i,
  output logic       start_o,
  output run_state_e state_o
);
  run_state_e state_q, state_d;
  run_state_e target_q, target_d;
  logic       armed_q, armed_d;
  logic       accept;
  logic       upd_en;
  run_state_e code;

  assign code   = run_state_e'(wr_code_i);
  assign accept = wr_state_i & ~busy_i;

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    armed_d  = armed_q;
    start_o  = 1'b0;
    if (soft_rst_i) begin
      state_d  = ST_STOPPED;
      target_d = ST_STOPPED;
      armed_d  = 1'b0;
      start_o  = 1'b1;
    end else if (accept) begin
      if (code == ST_CLEAR) begin
        if (state_q == ST_HELD) begin
          if (armed_q) begin
            target_d = ST_STOPPED;
            armed_d  = 1'b0;
            start_o  = 1'b1;
          end else begin
            armed_d = 1'b1;
          end
        end
      end else begin
        target_d = code;
        armed_d  = 1'b0;
        start_o  = 1'b1;
      end
    end else if (done_i) begin
      state_d = target_q;
    end
  end

  assign upd_en = soft_rst_i | accept | done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_STOPPED;
      target_q <= ST_STOPPED;
      armed_q  <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      target_q <= target_d;
      armed_q  <= armed_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/xsc_err_bank.sv
module xsc_err_bank #(
  parameter int unsigned NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all_i,
  input  logic [NUM_ERR-1:0] event_i,
  input  logic               w1c_en_i,
  input  logic [NUM_ERR-1:0] w1c_mask_i,
  input  logic               en_wr_i,
  input  logic [NUM_ERR-1:0] en_data_i,
  output logic [NUM_ERR-1:0] flags_o,
  output logic               irq_o
);
  logic [NUM_ERR-1:0] flag_q;
  logic [NUM_ERR-1:0] en_q, en_d;
  logic               en_upd;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    logic flag_d;
    logic flag_upd;
    always_comb begin
      flag_d = flag_q[i];
      if (clr_all_i)                       flag_d = 1'b0;
      else if (event_i[i])                 flag_d = 1'b1;
      else if (w1c_en_i && w1c_mask_i[i])  flag_d = 1'b0;
    end
    assign flag_upd = clr_all_i | event_i[i] | w1c_en_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (flag_upd) flag_q[i] <= flag_d;
    end
  end

  always_comb begin
    en_d = en_q;
    if (clr_all_i)    en_d = '0;
    else if (en_wr_i) en_d = en_data_i;
  end

  assign en_upd = clr_all_i | en_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_q);

endmodule

// File: rtl/xfer_state_ctrl.sv
module xfer_state_ctrl
  import xsc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_ERR    = 4,
  parameter int unsigned ERR_LSB    = 2,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_ERR-1:0] err_event_i,
  output logic [DATA_W-1:0]  state_word_o,
  output logic [DATA_W-1:0]  err_flags_o,
  output logic               irq_o,
  output logic               shift_en_o
);
  logic               wr_state, soft_rst, wr_err, wr_en_reg;
  logic               start, busy, done;
  run_state_e         cur_state;
  logic [NUM_ERR-1:0] flags;
  logic               unused_wdata;

  assign wr_state  = wr_en_i && (wr_addr_i == RA_STATE);
  assign soft_rst  = wr_en_i && (wr_addr_i == RA_SOFTRST) && wr_data_i[0];
  assign wr_err    = wr_en_i && (wr_addr_i == RA_ERR);
  assign wr_en_reg = wr_en_i && (wr_addr_i == RA_ERREN);
  assign unused_wdata = ^wr_data_i;

  xsc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  xsc_state_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_state_i(wr_state),
    .wr_code_i (wr_data_i[1:0]),
    .soft_rst_i(soft_rst),
    .busy_i    (busy),
    .done_i    (done),
    .start_o   (start),
    .state_o   (cur_state)
  );

  xsc_err_bank #(.NUM_ERR(NUM_ERR)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (soft_rst),
    .event_i   (err_event_i),
    .w1c_en_i  (wr_err),
    .w1c_mask_i(wr_data_i[ERR_LSB +: NUM_ERR]),
    .en_wr_i   (wr_en_reg),
    .en_data_i (wr_data_i[ERR_LSB +: NUM_ERR]),
    .flags_o   (flags),
    .irq_o     (irq_o)
  );

  always_comb begin
    state_word_o            = '0;
    state_word_o[1:0]       = cur_state;
    state_word_o[VALID_POS] = ~busy;
    err_flags_o             = '0;
    err_flags_o[ERR_LSB +: NUM_ERR] = flags;
  end

  assign shift_en_o = ~busy && (cur_state == ST_ACTIVE);

endmodule

// File: rtl/xfer_state_ctrl_sva.sv
module xfer_state_ctrl_sva #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_ERR    = 4,
  parameter int unsigned ERR_LSB    = 2,
  parameter int unsigned SETTLE_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [1:0]         wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_ERR-1:0] err_event_i,
  input logic [DATA_W-1:0]  state_word_o,
  input logic [DATA_W-1:0]  err_flags_o,
  input logic               irq_o,
  input logic               shift_en_o
);
  logic               valid;
  logic [1:0]         st;
  logic [NUM_ERR-1:0] fl;
  logic               soft_w, st_w, err_w;
  logic [31:0]        low_cnt;

  assign valid  = state_word_o[2];
  assign st     = state_word_o[1:0];
  assign fl     = err_flags_o[ERR_LSB +: NUM_ERR];
  assign soft_w = wr_en_i && (wr_addr_i == 2'd1) && wr_data_i[0];
  assign st_w   = wr_en_i && (wr_addr_i == 2'd0);
  assign err_w  = wr_en_i && (wr_addr_i == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (soft_w)   low_cnt <= '0;
    else if (!valid)   low_cnt <= low_cnt + 1;
    else               low_cnt <= '0;
  end

  // R2 and R3: a window never outlasts SETTLE_CYC, even with dropped writes
  assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= SETTLE_CYC);

  assert_hold_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !$past(valid) && !$past(soft_w)) |-> $stable(st));

  assert_first_clear_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && st == 2'd3 && st_w && wr_data_i[1:0] == 2'd2 && !soft_w) |=> st == 2'd3);

  assert_clear_outside_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && st != 2'd3 && st_w && wr_data_i[1:0] == 2'd2) |=> (valid && $stable(st)));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_w |=> (st == 2'd0 && !valid && fl == '0 && !irq_o));

  assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_event_i && !soft_w) |=> ((fl & $past(err_event_i)) == $past(err_event_i)));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_w && err_event_i == '0) |=> ((fl & $past(wr_data_i[ERR_LSB +: NUM_ERR])) == '0));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (fl != '0));

  assert_shift_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_o |-> (valid && st == 2'd1));

endmodule

bind xfer_state_ctrl xfer_state_ctrl_sva #(
  .DATA_W(DATA_W), .NUM_ERR(NUM_ERR), .ERR_LSB(ERR_LSB), .SETTLE_CYC(SETTLE_CYC)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .err_event_i(err_event_i), .state_word_o(state_word_o),
  .err_flags_o(err_flags_o), .irq_o(irq_o), .shift_en_o(shift_en_o)
);

// File: tb/xfer_state_ctrl_test.sv
`timescale 1ns/1ps
module xfer_state_ctrl_test;
  localparam int SETTLE = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  err_event;
  logic [15:0] state_word;
  logic [15:0] err_flags;
  logic        irq;
  logic        shift_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  xfer_state_ctrl #(.DATA_W(16), .NUM_ERR(4), .ERR_LSB(2), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .err_event_i(err_event), .state_word_o(state_word),
    .err_flags_o(err_flags), .irq_o(irq), .shift_en_o(shift_en)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!state_word[2] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic go_state(input logic [1:0] code);
    int n;
    do_write(2'd0, {14'd0, code});
    wait_valid(n);
  endtask

  task automatic pulse_event(input logic [3:0] m);
    err_event = m;
    @(negedge clk);
    err_event = '0;
  endtask

  task automatic t_reset;
    check(state_word == 16'h0004, "R1 state word", state_word, 16'h0004);
    check(err_flags == 16'h0000, "R1 flags", err_flags, 0);
    check(!irq && !shift_en, "R1 irq/shift", {irq, shift_en}, 0);
  endtask

  task automatic t_run;
    int n;
    do_write(2'd0, 16'd1);
    check(state_word == 16'h0000, "R2 old code held, flag low", state_word, 16'h0000);
    wait_valid(n);
    check(n == SETTLE, "R2 window length", n, SETTLE);
    check(state_word == 16'h0005, "R2 committed active", state_word, 16'h0005);
    check(shift_en, "R10 shift in active", shift_en, 1);
  endtask

  task automatic t_ignore_busy;
    int n;
    do_write(2'd0, 16'd3);
    check(!shift_en, "R10 no shift while settling", shift_en, 0);
    do_write(2'd0, 16'd0);
    wait_valid(n);
    check(n == SETTLE - 1, "R3 window not extended", n, SETTLE - 1);
    check(state_word == 16'h0007, "R3 dropped write", state_word, 16'h0007);
    check(!shift_en, "R10 no shift in hold", shift_en, 0);
  endtask

  task automatic t_double_clear;
    int n;
    do_write(2'd0, 16'd2);
    check(state_word == 16'h0007, "R4 first clear holds", state_word, 16'h0007);
    repeat (6) @(negedge clk);
    check(state_word == 16'h0007, "R4 still held", state_word, 16'h0007);
    do_write(2'd0, 16'd2);
    check(state_word == 16'h0003, "R4 second clear starts window", state_word, 16'h0003);
    wait_valid(n);
    check(n == SETTLE, "R4 window length", n, SETTLE);
    check(state_word == 16'h0004, "R4 reached stopped", state_word, 16'h0004);
  endtask

  task automatic t_cancel;
    int n;
    go_state(2'd3);
    do_write(2'd0, 16'd2);
    go_state(2'd3);
    do_write(2'd0, 16'd2);
    check(state_word == 16'h0007, "R5 arming cancelled", state_word, 16'h0007);
    repeat (SETTLE + 2) @(negedge clk);
    check(state_word == 16'h0007, "R5 still held", state_word, 16'h0007);
    do_write(2'd0, 16'd2);
    wait_valid(n);
    check(state_word == 16'h0004, "R5 second clear completes", state_word, 16'h0004);
    do_write(2'd0, 16'd2);
    check(state_word == 16'h0004, "R5 clear in stopped", state_word, 16'h0004);
    go_state(2'd1);
    do_write(2'd0, 16'd2);
    check(state_word == 16'h0005, "R5 clear in active", state_word, 16'h0005);
  endtask

  task automatic t_soft_reset;
    int n;
    do_write(2'd3, 16'h0004);
    pulse_event(4'b0001);
    check(irq, "R9 irq enabled flag", irq, 1);
    do_write(2'd1, 16'd0);
    check(state_word == 16'h0005 && err_flags == 16'h0004, "R6 zero write ignored",
          state_word, 16'h0005);
    do_write(2'd0, 16'd3);
    do_write(2'd1, 16'd1);
    check(state_word == 16'h0000, "R6 forced stopped, flag low", state_word, 16'h0000);
    check(err_flags == 0 && !irq, "R6 flags cleared", err_flags, 0);
    wait_valid(n);
    check(n == SETTLE, "R6 full window", n, SETTLE);
    check(state_word == 16'h0004, "R6 settles stopped", state_word, 16'h0004);
    pulse_event(4'b0001);
    check(!irq, "R6 enables cleared", irq, 0);
    do_write(2'd2, 16'hFFFF);
  endtask

  task automatic t_errors;
    for (int i = 0; i < 4; i++) begin
      pulse_event(4'(1 << i));
      check(err_flags == 16'(1 << (i + 2)), "R7 flag position", err_flags, 1 << (i + 2));
      do_write(2'd2, 16'(1 << (i + 2)));
      check(err_flags == 0, "R8 clear", err_flags, 0);
    end
    pulse_event(4'b1111);
    do_write(2'd2, 16'h0008);
    check(err_flags == 16'h0034, "R8 selective clear", err_flags, 16'h0034);
    err_event = 4'b0001;
    do_write(2'd2, 16'h0004);
    err_event = 0;
    check(err_flags == 16'h0034, "R8 event wins", err_flags, 16'h0034);
    do_write(2'd2, 16'hFFFF);
    do_write(2'd3, 16'h0020);
    pulse_event(4'b0001);
    check(!irq, "R9 masked flag", irq, 0);
    pulse_event(4'b1000);
    check(irq, "R9 enabled flag", irq, 1);
    do_write(2'd2, 16'h0020);
    check(!irq && err_flags == 16'h0004, "R9 irq drops", irq, 0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; err_event = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run();
    t_ignore_busy();
    t_double_clear();
    t_cancel();
    t_soft_reset();
    t_errors();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule